// File: doc/BRIEF.md
# Banked Bit-Set Execute Unit

This unit carries out one instruction: it sets a single bit of a byte in an 8-bit register file by reading the byte, modifying it and writing it back. A caller pulses `start` with a 16-bit instruction word. With the same pulse it supplies the current 4-bit bank register, the extended-mode flag and a 12-bit index pointer. The unit captures all of these. It then runs one instruction cycle of four phases: decode, read, process and write. The read and write strobes of its internal data memory are visible at the ports.

The 12-bit operand address comes from one of three modes. The access selector bit of the instruction and the extended-mode flag choose the mode. The modes are a fixed split access window, paging through the bank register, and a pointer-plus-offset form for small file addresses. A word whose opcode is not bit-set still runs through the four phases, but it never writes. No flags are produced.

Top module: `bitset_exec`

## Requirements
- R1: The unit treats an instruction word as bit-set when word[15:12] is 4'b1000. In that case word[11:9] is the bit number b, word[8] is the access selector a and word[7:0] is the file address f.
- R2: In the write phase the write byte equals the byte read in the read phase with bit b forced to 1. All other bits keep their read value. For example, a byte of 8'h0A with b = 7 gives 8'h8A.
- R3: When a = 1 the address is {bank, f}, and `amode` reads 1.
- R4: When a = 0 and either extended mode is off or f > 8'h5F, the access window is used. For f < 8'h80 the address is 12'h000 + f, otherwise 12'hF00 + f. In this mode `amode` reads 0.
- R5: When a = 0, extended mode is on and f <= 8'h5F, the address is (pointer + f) modulo 4096, and `amode` reads 2.
- R6: A `start` sampled while idle begins an operation. `busy` is high for exactly four cycles, and `phase` counts 0 (decode), 1 (read), 2 (process) and 3 (write). `mem_rd` is high only in phase 1 and `mem_wr` only in phase 3. A `start` sampled while busy is ignored.
- R7: A word that is not bit-set produces no write. `mem_wr` stays low, and the stored byte is unchanged on a later read.
- R8: After reset, the memory entry at index i holds (i*37 + 5) mod 256. The index is the low MEM_AW bits of the address (8 by default). `mem_rdata` shows the byte read, from phase 2 until the next read.
- R9: While idle, `busy`, `mem_rd` and `mem_wr` are low. `mem_addr` stays fixed from the read phase through the write phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| instr | input | 16 | Instruction word |
| bank | input | 4 | Bank register value |
| ext_en | input | 1 | Extended addressing mode enable |
| idx_ptr | input | 12 | Index pointer for offset addressing |
| busy | output | 1 | Operation in progress |
| phase | output | 2 | Current phase: 0 decode, 1 read, 2 process, 3 write |
| amode | output | 2 | Address mode: 0 access, 1 banked, 2 indexed |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 12 | Operand address |
| mem_wdata | output | 8 | Modified byte being written |
| mem_rdata | output | 8 | Byte read from memory |

## Verification
Some properties hold on every cycle, and the assertions cover those. They check the phase order, that the write comes exactly two cycles after the read, and that the address is held between the two. They check that the write byte differs from the read byte in at most one bit and never clears a bit. They check that the strobes stay silent when idle and that an operation ends after its write phase.

Other behaviour depends on values that only a reference model can supply, so only the bench scenarios show it. That covers which address each of the three modes yields, wraparound of the pointer sum, and the boundary at f = 8'h5F/8'h60 and at 8'h7F/8'h80. It also covers whether an earlier write actually landed in memory and whether a non-bit-set word left the memory alone.

// File: rtl/bitset_pkg.sv
package bitset_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned BANK_W = 4;
  localparam int unsigned FILE_W = 8;
  localparam int unsigned BIT_W  = 3;
  localparam int unsigned WORD_W = 16;

  typedef enum logic [1:0] {
    PH_DECODE = 2'd0,
    PH_READ   = 2'd1,
    PH_PROC   = 2'd2,
    PH_WRITE  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    AM_ACCESS  = 2'd0,
    AM_BANKED  = 2'd1,
    AM_INDEXED = 2'd2
  } amode_e;

  typedef struct packed {
    logic              is_set;
    logic [BIT_W-1:0]  bitno;
    logic              acc;
    logic [FILE_W-1:0] f;
  } fields_t;

  // choose how the operand address is formed
  function automatic amode_e pick_mode(input logic acc, input logic ext,
                                       input logic [FILE_W-1:0] f,
                                       input logic [FILE_W-1:0] limit);
    if (acc)                  return AM_BANKED;
    if (ext && (f <= limit))  return AM_INDEXED;
    return AM_ACCESS;
  endfunction

  // operand address for a given mode
  function automatic logic [ADDR_W-1:0] form_addr(input amode_e m,
                                                  input logic [BANK_W-1:0] bsr,
                                                  input logic [ADDR_W-1:0] ptr,
                                                  input logic [FILE_W-1:0] f);
    logic [ADDR_W-1:0] r;
    case (m)
      AM_BANKED:  r = {bsr, f};
      AM_INDEXED: r = ptr + {{(ADDR_W-FILE_W){1'b0}}, f};
      default:    r = f[FILE_W-1] ? {{(ADDR_W-FILE_W){1'b1}}, f}
                                  : {{(ADDR_W-FILE_W){1'b0}}, f};
    endcase
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] set_mask(input logic [BIT_W-1:0] b);
    return DATA_W'(1) << b;
  endfunction

  function automatic logic [DATA_W-1:0] init_byte(input int unsigned idx);
    return DATA_W'((idx * 37 + 5) % 256);
  endfunction
endpackage

// File: rtl/bitset_decode.sv
module bitset_decode
  import bitset_pkg::*;
#(
  parameter logic [3:0] OPCODE = 4'b1000
) (
  input  logic [WORD_W-1:0] word,
  output fields_t           flds
);
  assign flds.is_set = (word[WORD_W-1 -: 4] == OPCODE);
  assign flds.bitno  = word[11:9];
  assign flds.acc    = word[8];
  assign flds.f      = word[FILE_W-1:0];
endmodule

// File: rtl/bitset_agen.sv
module bitset_agen
  import bitset_pkg::*;
#(
  parameter logic [FILE_W-1:0] OFFSET_LIMIT = 8'h5F
) (
  input  fields_t           flds,
  input  logic [BANK_W-1:0] bsr,
  input  logic              ext,
  input  logic [ADDR_W-1:0] ptr,
  output amode_e            mode,
  output logic [ADDR_W-1:0] addr
);
  assign mode = pick_mode(flds.acc, ext, flds.f, OFFSET_LIMIT);
  assign addr = form_addr(mode, bsr, ptr, flds.f);
endmodule

// File: rtl/bitset_seq.sv
module bitset_seq
  import bitset_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output logic   accept,
  output logic   active,
  output phase_e ph
);
  assign accept = start && !active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      ph     <= PH_DECODE;
    end else if (accept) begin
      active <= 1'b1;
      ph     <= PH_DECODE;
    end else if (active) begin
      if (ph == PH_WRITE) active <= 1'b0;
      ph <= phase_e'(ph + 2'd1);
    end
  end
endmodule

// File: rtl/bitset_regfile.sv
module bitset_regfile
  import bitset_pkg::*;
#(
  parameter int unsigned MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << MEM_AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [MEM_AW-1:0] idx;

  assign idx = addr[MEM_AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= init_byte(i);
      rdata <= '0;
    end else begin
      if (rd) rdata <= mem[idx];
      if (wr) mem[idx] <= wdata;
    end
  end
endmodule

// File: rtl/bitset_exec.sv
module bitset_exec
  import bitset_pkg::*;
#(
  parameter int unsigned       MEM_AW       = 8,
  parameter logic [3:0]        OPCODE       = 4'b1000,
  parameter logic [FILE_W-1:0] OFFSET_LIMIT = 8'h5F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] instr,
  input  logic [BANK_W-1:0] bank,
  input  logic              ext_en,
  input  logic [ADDR_W-1:0] idx_ptr,
  output logic              busy,
  output logic [1:0]        phase,
  output logic [1:0]        amode,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] mem_rdata
);
  logic              accept;
  logic              active;
  phase_e            ph;
  logic [WORD_W-1:0] word_q;
  logic [BANK_W-1:0] bank_q;
  logic              ext_q;
  logic [ADDR_W-1:0] ptr_q;
  fields_t           flds;
  amode_e            mode_d, mode_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              rd_evt, wr_evt;

  bitset_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .accept(accept), .active(active), .ph(ph)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      bank_q <= '0;
      ext_q  <= 1'b0;
      ptr_q  <= '0;
    end else if (accept) begin
      word_q <= instr;
      bank_q <= bank;
      ext_q  <= ext_en;
      ptr_q  <= idx_ptr;
    end
  end

  bitset_decode #(.OPCODE(OPCODE)) u_dec (.word(word_q), .flds(flds));

  bitset_agen #(.OFFSET_LIMIT(OFFSET_LIMIT)) u_agen (
    .flds(flds), .bsr(bank_q), .ext(ext_q), .ptr(ptr_q),
    .mode(mode_d), .addr(addr_d)
  );

  // address latched in the decode phase, held through write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mode_q <= AM_ACCESS;
    end else if (active && ph == PH_DECODE) begin
      addr_q <= addr_d;
      mode_q <= mode_d;
    end
  end

  assign rd_evt = active && (ph == PH_READ);
  assign wr_evt = active && (ph == PH_WRITE) && flds.is_set;

  bitset_regfile #(.MEM_AW(MEM_AW)) u_rf (
    .clk(clk), .rst_n(rst_n), .rd(rd_evt), .wr(wr_evt),
    .addr(addr_q), .wdata(wdata_q), .rdata(mem_rdata)
  );

  // process phase: merge the one-hot mask
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       wdata_q <= '0;
    else if (active && ph == PH_PROC) wdata_q <= mem_rdata | set_mask(flds.bitno);
  end

  assign busy      = active;
  assign phase     = ph;
  assign amode     = mode_q;
  assign mem_rd    = rd_evt;
  assign mem_wr    = wr_evt;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
endmodule

// File: rtl/bitset_exec_chk.sv
module bitset_exec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        accept,
  input logic        busy,
  input logic [1:0]  phase,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [11:0] mem_addr,
  input logic [7:0]  mem_wdata,
  input logic [7:0]  mem_rdata
);
  // R6
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && phase == 2'd0));

  // R6
  read_then_proc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (phase == 2'd2 && !mem_rd && busy));

  // R6
  write_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd, 2));

  // R2
  single_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (((mem_wdata & mem_rdata) == mem_rdata) &&
                ($countones(mem_wdata ^ mem_rdata) <= 1)));

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_addr == $past(mem_addr, 2)));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr));

  // R6
  op_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase == 2'd3) |=> !busy);
endmodule

bind bitset_exec bitset_exec_chk u_chk (.*);

// File: tb/bitset_exec_tb.sv
module bitset_exec_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic [3:0]  bank = '0;
  logic        ext_en = 1'b0;
  logic [11:0] idx_ptr = '0;
  logic        busy, mem_rd, mem_wr;
  logic [1:0]  phase, amode;
  logic [11:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [256];

  always #5 clk = ~clk;

  bitset_exec u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .bank(bank),
    .ext_en(ext_en), .idx_ptr(idx_ptr), .busy(busy), .phase(phase),
    .amode(amode), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference address model, written from the requirements
  function automatic logic [1:0] ref_mode(input logic [15:0] w, input logic ext);
    if (w[8]) return 2'd1;
    if (ext && w[7:0] < 8'h60) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [11:0] ref_addr(input logic [15:0] w, input logic [3:0] bk,
                                           input logic ext, input logic [11:0] p);
    case (ref_mode(w, ext))
      2'd1:    return {bk, w[7:0]};
      2'd2:    return 12'((p + w[7:0]) % 4096);
      default: return (w[7:0] >= 8'h80) ? (12'hF00 + w[7:0]) : {4'h0, w[7:0]};
    endcase
  endfunction

  task automatic run_op(input logic [15:0] w, input logic [3:0] bk, input logic ext,
                        input logic [11:0] p, input bit poke);
    logic [11:0] ea;
    logic [7:0]  old_v, new_v;
    bit          is_set;
    is_set = (w[15:12] == 4'b1000);
    ea     = ref_addr(w, bk, ext, p);
    old_v  = model[ea[7:0]];
    new_v  = old_v | (8'd1 << w[11:9]);
    @(negedge clk);
    start = 1'b1; instr = w; bank = bk; ext_en = ext; idx_ptr = p;
    @(negedge clk);                       // decode phase
    start = poke;
    instr = 16'($urandom); bank = 4'($urandom); ext_en = 1'($urandom); idx_ptr = 12'($urandom);
    chk(busy && phase == 2'd0 && !mem_rd, "R6 decode", {busy, phase}, 3'b100);
    @(negedge clk);                       // read phase
    start = 1'b0;
    chk(mem_rd && phase == 2'd1, "R6 read strobe", {mem_rd, phase}, 3'b101);
    chk(mem_addr == ea, "R3/R4/R5 address", mem_addr, ea);
    chk(amode == ref_mode(w, ext), "R3/R4/R5 mode", amode, ref_mode(w, ext));
    @(negedge clk);                       // process phase
    chk(mem_rdata == old_v, "R8 read data", mem_rdata, old_v);
    @(negedge clk);                       // write phase
    chk(mem_wr == is_set, "R1/R7 write strobe", mem_wr, is_set);
    if (is_set) begin
      chk(mem_wdata == new_v, "R2 write data", mem_wdata, new_v);
      model[ea[7:0]] = new_v;
    end
    @(negedge clk);
    chk(!busy && !mem_rd && !mem_wr, "R6 R9 idle after op", busy, 0);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) model[i] = 8'((i * 37 + 5) % 256);
    repeat (3) @(negedge clk);
    chk(!busy && !mem_rd && !mem_wr, "R9 reset idle", {busy, mem_rd, mem_wr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && phase == 2'd0, "R9 idle after reset", {busy, phase}, 0);

    // R2 example: index 0x61 holds 0x0A, set bit 7 -> 0x8A
    run_op(16'h8E61, 4'h3, 1'b0, 12'h000, 1'b0);
    chk(model[8'h61] == 8'h8A, "R2 example", model[8'h61], 8'h8A);
    // R3 banked
    run_op(16'h8534, 4'hA, 1'b1, 12'h123, 1'b0);
    // R4 access window upper half, and boundaries 7F/80
    run_op(16'h8090, 4'h5, 1'b0, 12'h000, 1'b0);
    run_op(16'h827F, 4'h5, 1'b0, 12'h000, 1'b0);
    run_op(16'h8480, 4'h5, 1'b1 ^ 1'b1, 12'h000, 1'b0);
    // R5 indexed with wraparound at the limit, and just above limit
    run_op(16'h865F, 4'h1, 1'b1, 12'hFF0, 1'b0);
    run_op(16'h8860, 4'h1, 1'b1, 12'h200, 1'b0);
    run_op(16'h8A00, 4'h1, 1'b1, 12'h7FF, 1'b0);
    // R7 non-bit-set word, then reread the same byte
    run_op(16'h9E61, 4'h0, 1'b0, 12'h000, 1'b0);
    run_op(16'h9061, 4'h0, 1'b0, 12'h000, 1'b0);
    // R6 start while busy is ignored
    run_op(16'h8C10, 4'h2, 1'b0, 12'h000, 1'b1);
    // R1 same bit twice leaves byte unchanged the second time
    run_op(16'h8C10, 4'h2, 1'b0, 12'h000, 1'b0);

    for (int n = 0; n < 250; n++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if ($urandom % 4 != 0) w[15:12] = 4'b1000;
      run_op(w, 4'($urandom), 1'($urandom), 12'($urandom), 1'($urandom % 5 == 0));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule